// File: doc/BRIEF.md
# Dual-Mode External Cache SRAM Sequencer

This block turns a stream of single-word read and write requests from the core into pin-level control of a synchronous external cache SRAM. It drives the SRAM address bus, an active-low write strobe, an active-low output enable and the outgoing half of a split bidirectional data bus, and it returns read data to the core tagged with the sequence number of the request that fetched it.

Two timing modes are chosen by a static mode input. In the pipelined mode the SRAM runs at the core rate: one cycle puts out the address, one cycle accesses the array and one cycle returns data, and a new request can be taken every core cycle. In the half-rate mode the SRAM is clocked at half the core rate. Each address stays on the bus for two core cycles, and data occupies the following two. Writes use late-write timing, with data on the bus one SRAM cycle after the address. In both modes every access owns its own data slot, so any mix of reads and writes streams back to back with no idle turnaround cycles on the data bus.

Top module: `sram_seq`

## Requirements
- R1: In pipelined mode (mode input 0), a write accepted in cycle k drives the write strobe low in cycle k+1 only, with its address on the bus in that cycle.
- R2: In pipelined mode, a read accepted in cycle k puts its address on the bus in cycle k+1 and has output enable low and read-data-valid high in cycle k+3, the data being the SRAM data input of that cycle.
- R3: In pipelined mode the accept output is high in every cycle, so one request can be taken per core cycle.
- R4: In half-rate mode (mode input 1), the accept output is high only in even cycles counted from the first cycle after reset (cycle 0).
- R5: In half-rate mode, a request accepted in cycle k holds its address on the bus in cycles k+1 and k+2.
- R6: In half-rate mode, a read accepted in cycle k has output enable low in cycles k+3 and k+4, and read-data-valid high in cycle k+4 only.
- R7: In half-rate mode, a write accepted in cycle k has the write strobe low in cycles k+1 and k+2 and drives its data with the data-enable high in cycles k+3 and k+4.
- R8: The data-enable is high only in write data cycles and output enable is low only in read data cycles; the two are never active in the same cycle.
- R9: In either mode, a back-to-back stream of mixed reads and writes keeps the data bus busy in every cycle from the first data slot to the last one.
- R10: Requests complete in acceptance order; each read returns the value last written to its address and carries a tag equal to its acceptance count modulo 2^TAG_W, counting from 0 after reset.
- R11: While reset (active low) is asserted, the write strobe and output enable are high, the data-enable is low and read-data-valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | Timing mode: 0 pipelined, 1 half-rate late-write; static after reset |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | ADDR_W | Request word address |
| req_wdata_i | input | DATA_W | Write data |
| req_ready_o | output | 1 | Request taken at the clock edge when valid and ready are both high |
| rd_valid_o | output | 1 | Read data valid, one cycle per read |
| rd_data_o | output | DATA_W | Read data |
| rd_tag_o | output | TAG_W | Sequence number of the returning read |
| sram_addr_o | output | ADDR_W | SRAM address bus |
| sram_we_n_o | output | 1 | SRAM write strobe, active low |
| sram_oe_n_o | output | 1 | SRAM output enable, active low |
| sram_dq_i | input | DATA_W | Data bus, SRAM to block |
| sram_dq_o | output | DATA_W | Data bus, block to SRAM |
| sram_dq_oe_o | output | 1 | Block drives the data bus when high |

## Verification
Each mode is run with a burst of writes, a burst of reads, a back-to-back alternating read/write stream and sparse requests with idle gaps. The write and read bursts separate strobe timing from data-slot timing, the alternating stream shows whether a read slot and a write slot can sit in adjacent cycles without a gap or an overlap on the data bus, and the sparse traffic shows that idle cycles leave the strobes and enables inactive and that tags keep counting across gaps. A behavioural SRAM that answers two cycles after each address lets read data reveal a wrong address, a lost write or an ordering error.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic {
        MODE_PIPE = 1'b0,
        MODE_HALF = 1'b1
    } sram_mode_e;

endpackage

// File: rtl/sram_seq_phase.sv
module sram_seq_phase
    import sram_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_i,
    output logic slot_o
);
    typedef struct packed {
        logic odd;
    } ph_st_t;

    ph_st_t st_d, st_q;
    sram_mode_e mode;

    assign mode = sram_mode_e'(mode_i);

    always_comb begin
        st_d     = st_q;
        st_d.odd = ~st_q.odd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot_o = (mode == MODE_PIPE) ? 1'b1 : ~st_q.odd;

endmodule

// File: rtl/sram_seq_pipe.sv
module sram_seq_pipe
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              slot_i,
    input  logic              in_v_i,
    input  logic              in_w_i,
    input  logic [ADDR_W-1:0] in_addr_i,
    input  logic [DATA_W-1:0] in_wd_i,
    input  logic [TAG_W-1:0]  in_tag_i,
    output logic              a_v_o,
    output logic              a_w_o,
    output logic [ADDR_W-1:0] a_addr_o,
    output logic              d_v_o,
    output logic              d_w_o,
    output logic [DATA_W-1:0] d_wd_o,
    output logic [TAG_W-1:0]  d_tag_o
);
    typedef struct packed {
        logic              v;
        logic              w;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wd;
        logic [TAG_W-1:0]  tag;
    } acc_t;

    typedef struct packed {
        acc_t adr;
        acc_t mid;
        acc_t dat;
    } pipe_st_t;

    pipe_st_t   st_d, st_q;
    acc_t       incoming;
    sram_mode_e mode;

    assign mode = sram_mode_e'(mode_i);

    always_comb begin
        incoming.v    = in_v_i;
        incoming.w    = in_w_i;
        incoming.addr = in_v_i ? in_addr_i : st_q.adr.addr;
        incoming.wd   = in_wd_i;
        incoming.tag  = in_tag_i;

        st_d = st_q;
        if (slot_i) begin
            st_d.adr = incoming;
            if (mode == MODE_PIPE) begin
                st_d.mid = st_q.adr;
                st_d.dat = st_q.mid;
            end else begin
                st_d.mid = '0;
                st_d.dat = st_q.adr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign a_v_o    = st_q.adr.v;
    assign a_w_o    = st_q.adr.w;
    assign a_addr_o = st_q.adr.addr;
    assign d_v_o    = st_q.dat.v;
    assign d_w_o    = st_q.dat.w;
    assign d_wd_o   = st_q.dat.wd;
    assign d_tag_o  = st_q.dat.tag;

endmodule

// File: rtl/sram_seq_pins.sv
module sram_seq_pins #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_i,
    input  logic              a_v_i,
    input  logic              a_w_i,
    input  logic [ADDR_W-1:0] a_addr_i,
    input  logic              d_v_i,
    input  logic              d_w_i,
    input  logic [DATA_W-1:0] d_wd_i,
    input  logic [TAG_W-1:0]  d_tag_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [TAG_W-1:0]  rd_tag_o,
    output logic [ADDR_W-1:0] sram_addr_o,
    output logic              sram_we_n_o,
    output logic              sram_oe_n_o,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe_o
);
    always_comb begin
        sram_addr_o  = a_addr_i;
        sram_we_n_o  = ~(a_v_i & a_w_i);
        sram_oe_n_o  = ~(d_v_i & ~d_w_i);
        sram_dq_oe_o = d_v_i & d_w_i;
        sram_dq_o    = d_wd_i;
        rd_valid_o   = d_v_i & ~d_w_i & slot_i;
        rd_data_o    = dq_i;
        rd_tag_o     = d_tag_i;
    end

    // R8
    bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sram_dq_oe_o && !sram_oe_n_o));

    // R8
    rdv_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> (!sram_oe_n_o && !sram_dq_oe_o));

endmodule

// File: rtl/sram_seq.sv
module sram_seq
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              req_ready_o,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [TAG_W-1:0]  rd_tag_o,
    output logic [ADDR_W-1:0] sram_addr_o,
    output logic              sram_we_n_o,
    output logic              sram_oe_n_o,
    input  logic [DATA_W-1:0] sram_dq_i,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe_o
);
    typedef struct packed {
        logic [TAG_W-1:0] seq;
    } top_st_t;

    top_st_t st_d, st_q;

    logic              slot;
    logic              take;
    logic              a_v, a_w, d_v, d_w;
    logic [ADDR_W-1:0] a_addr;
    logic [DATA_W-1:0] d_wd;
    logic [TAG_W-1:0]  d_tag;

    assign req_ready_o = slot;
    assign take        = req_valid_i & slot;

    always_comb begin
        st_d = st_q;
        if (take) st_d.seq = st_q.seq + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    sram_seq_phase u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode_i),
        .slot_o (slot)
    );

    sram_seq_pipe #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W)
    ) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .slot_i    (slot),
        .in_v_i    (take),
        .in_w_i    (req_write_i),
        .in_addr_i (req_addr_i),
        .in_wd_i   (req_wdata_i),
        .in_tag_i  (st_q.seq),
        .a_v_o     (a_v),
        .a_w_o     (a_w),
        .a_addr_o  (a_addr),
        .d_v_o     (d_v),
        .d_w_o     (d_w),
        .d_wd_o    (d_wd),
        .d_tag_o   (d_tag)
    );

    sram_seq_pins #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W)
    ) u_pins (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot_i       (slot),
        .a_v_i        (a_v),
        .a_w_i        (a_w),
        .a_addr_i     (a_addr),
        .d_v_i        (d_v),
        .d_w_i        (d_w),
        .d_wd_i       (d_wd),
        .d_tag_i      (d_tag),
        .dq_i         (sram_dq_i),
        .rd_valid_o   (rd_valid_o),
        .rd_data_o    (rd_data_o),
        .rd_tag_o     (rd_tag_o),
        .sram_addr_o  (sram_addr_o),
        .sram_we_n_o  (sram_we_n_o),
        .sram_oe_n_o  (sram_oe_n_o),
        .sram_dq_o    (sram_dq_o),
        .sram_dq_oe_o (sram_dq_oe_o)
    );

    // R1
    pipe_we_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && req_valid_i && req_ready_o && req_write_i) |=> !sram_we_n_o);

    // R4
    half_ready_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && req_ready_o) |=> !req_ready_o);

    // R5
    half_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && !req_ready_o) |=> $stable(sram_addr_o));

    // R7
    half_we_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && $fell(sram_we_n_o)) |=> !sram_we_n_o);

    // R6
    half_oe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && $fell(sram_oe_n_o)) |=> !sram_oe_n_o);

endmodule

// File: tb/sram_seq_tb_top.sv
`timescale 1ns/1ps
module sram_seq_tb_top;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int TW = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic [TW-1:0] rd_tag;
    logic [AW-1:0] sram_addr;
    logic          sram_we_n, sram_oe_n, sram_dq_oe;
    logic [DW-1:0] sram_dq_i, sram_dq_o;

    always #4 clk = ~clk;

    sram_seq #(.ADDR_W(AW), .DATA_W(DW), .TAG_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .req_valid_i(req_valid), .req_write_i(req_write),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .req_ready_o(req_ready), .rd_valid_o(rd_valid),
        .rd_data_o(rd_data), .rd_tag_o(rd_tag),
        .sram_addr_o(sram_addr), .sram_we_n_o(sram_we_n),
        .sram_oe_n_o(sram_oe_n), .sram_dq_i(sram_dq_i),
        .sram_dq_o(sram_dq_o), .sram_dq_oe_o(sram_dq_oe)
    );

    function automatic logic [DW-1:0] pat(input int a);
        return DW'((a * 16'h9e37) ^ 16'h5a5a);
    endfunction

    // behavioural SRAM: answers two cycles after each address
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] h1a, h2a;
    logic          h1w, h2w;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= pat(i);
            h1a <= '0; h2a <= '0; h1w <= 1'b0; h2w <= 1'b0;
        end else begin
            h1a <= sram_addr; h1w <= !sram_we_n;
            h2a <= h1a;       h2w <= h1w;
            if (sram_dq_oe && h2w) mem[h2a] <= sram_dq_o;
        end
    end
    assign sram_dq_i = sram_oe_n ? '0 : mem[h2a];

    int errors = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference model state
    int            k = 0;
    int            tagc = 0;
    logic [DW-1:0] ref_mem [DEPTH];
    bit            exp_we   [int];
    int            exp_bus  [int];
    logic [DW-1:0] exp_wd   [int];
    bit            exp_rv   [int];
    int            exp_tag  [int];
    logic [DW-1:0] exp_dat  [int];
    logic [AW-1:0] exp_addr [int];
    bit            busy     [int];
    bit            track = 0;
    int            first_k = -1;
    int            last_k = -1;

    task automatic cycle_check();
        bit   exp_rdy;
        int   bus;
        bit   want_rv;
        string rr, rw, rd;
        rr = mode ? "R4" : "R3";
        rw = mode ? "R7" : "R1";
        rd = mode ? "R6" : "R2";
        exp_rdy = !mode || (k % 2 == 0);
        chk(req_ready == exp_rdy, rr, req_ready, exp_rdy);
        chk(sram_we_n == !exp_we.exists(k), rw, sram_we_n, !exp_we.exists(k));
        bus = exp_bus.exists(k) ? exp_bus[k] : 0;
        chk(sram_oe_n == (bus != 1), rd, sram_oe_n, bus != 1);
        chk(sram_dq_oe == (bus == 2), "R8", sram_dq_oe, bus == 2);
        chk(!(!sram_oe_n && sram_dq_oe), "R8", sram_dq_oe, 0);
        if (bus == 2) chk(sram_dq_o == exp_wd[k], mode ? "R7" : "R1", sram_dq_o, exp_wd[k]);
        want_rv = exp_rv.exists(k);
        chk(rd_valid == want_rv, rd, rd_valid, want_rv);
        if (want_rv && rd_valid) begin
            chk(rd_tag == TW'(exp_tag[k]), "R10", rd_tag, exp_tag[k]);
            chk(rd_data == exp_dat[k], "R10", rd_data, exp_dat[k]);
        end
        if (exp_addr.exists(k)) chk(sram_addr == exp_addr[k], mode ? "R5" : "R2", sram_addr, exp_addr[k]);
        busy[k] = !sram_oe_n || sram_dq_oe;

        if (req_valid && req_ready) begin
            int dl;
            dl = mode ? 4 : 3;
            exp_addr[k+1] = req_addr;
            if (mode) exp_addr[k+2] = req_addr;
            if (req_write) begin
                exp_we[k+1] = 1;
                if (mode) exp_we[k+2] = 1;
                exp_bus[k+3] = 2; exp_wd[k+3] = req_wdata;
                if (mode) begin exp_bus[k+4] = 2; exp_wd[k+4] = req_wdata; end
                ref_mem[req_addr] = req_wdata;
            end else begin
                exp_bus[k+3] = 1;
                if (mode) exp_bus[k+4] = 1;
                exp_rv[k+dl]  = 1;
                exp_tag[k+dl] = tagc % (1 << TW);
                exp_dat[k+dl] = ref_mem[req_addr];
            end
            tagc++;
            if (track) begin
                if (first_k < 0) first_k = k;
                last_k = k;
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (!rst_n) begin
                k = 0; tagc = 0;
                for (int i = 0; i < DEPTH; i++) ref_mem[i] = pat(i);
                exp_we.delete(); exp_bus.delete(); exp_wd.delete(); exp_rv.delete();
                exp_tag.delete(); exp_dat.delete(); exp_addr.delete(); busy.delete();
            end else begin
                k++;
            end
            #6;
            if (rst_n) cycle_check();
        end
    end

    task automatic issue(input bit w, input int a, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = AW'(a); req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic run_mode(input bit m);
        int lo, hi, cnt;
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; mode = m;
        repeat (3) @(negedge clk);
        #1;
        // R11 reset state
        chk(sram_we_n == 1'b1, "R11", sram_we_n, 1);
        chk(sram_oe_n == 1'b1, "R11", sram_oe_n, 1);
        chk(sram_dq_oe == 1'b0, "R11", sram_dq_oe, 0);
        chk(rd_valid == 1'b0, "R11", rd_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // write burst
        for (int i = 0; i < 8; i++) issue(1'b1, i, DW'(16'h1000 + i * 3 + (m ? 16'h0800 : 0)));
        idle(6);
        // read burst, including addresses never written
        for (int i = 0; i < 10; i++) issue(1'b0, i, '0);
        idle(6);
        // back-to-back mixed stream, R9
        track = 1; first_k = -1; last_k = -1;
        for (int i = 0; i < 12; i++) issue(i % 2 == 1, i % 4, DW'(16'hc000 + i));
        track = 0;
        idle(8);
        lo = first_k + 3;
        hi = last_k + (m ? 4 : 3);
        cnt = 0;
        for (int c = lo; c <= hi; c++) if (busy.exists(c) && busy[c]) cnt++;
        chk(cnt == hi - lo + 1, "R9", cnt, hi - lo + 1);
        // sparse traffic with gaps
        for (int i = 0; i < 20; i++) begin
            issue(1'($urandom_range(0, 1)), int'($urandom_range(0, 15)), DW'($urandom));
            if (i % 3 == 0) idle(int'($urandom_range(1, 4)));
        end
        idle(10);
    endtask

    initial begin
        #800000;
        errors++; checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        run_mode(1'b0);
        run_mode(1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule